// File: doc/BRIEF.md
# Transactional Footprint and Conflict Tracker

This block keeps the address footprint of one hardware memory transaction. It is a small fully associative table of cache lines. Each entry holds a line tag and two flags, one for lines the transaction has read and one for lines it has written. The core presents its own transactional loads and stores on a local request port. Accesses from other agents, whether transactional or not, arrive on a snoop port. The block turns these into three results: a sticky conflict failure, a sticky capacity failure, and a one-cycle indication that a suspended-mode load has hit a line the transaction has written, which tells the core whether it may forward the speculative value.

Two kinds of transaction are supported. An atomic transaction records both reads and writes and checks every snoop against them, so the isolation also holds against non-transactional traffic. A rollback-only transaction records stores only and never reports a snoop conflict. Ports carry line addresses, meaning the byte-address bits above the 64-byte line offset. A commit or abort pulse empties the table and ends the transaction in a single cycle. The data buffering and the cache itself live outside this block.

Top module: `txfp_tracker`

## Requirements
- R1: After reset, tx_active_o, fail_conflict_o, fail_capacity_o and fwd_hit_o are all low and the table holds no lines.
- R2: A begin pulse while no transaction is active starts one in the mode given by tx_mode_i (0 = atomic, 1 = rollback-only), and tx_active_o is high from the next cycle. A begin pulse during an active transaction is ignored and leaves the mode unchanged.
- R3: In atomic mode, a snoop write to any tracked line raises fail_conflict_o in the next cycle.
- R4: In atomic mode, a snoop read raises fail_conflict_o only if it hits a line the transaction has written. A snoop read of a line that was only read causes no failure.
- R5: Lines match on all LINE_W address bits. A snoop to a line that differs from a tracked line in any bit, including the most significant one, causes no failure.
- R6: NUM_ENT distinct lines fit in the table. A new line beyond that raises fail_capacity_o in the next cycle. Accesses to lines already held use no further entries.
- R7: In rollback-only mode, loads are not recorded and snoops never raise a conflict. Stores are recorded and count against capacity.
- R8: While susp_i is high, loads and stores allocate no entries.
- R9: A suspended store to a tracked line raises fail_conflict_o in the next cycle. This holds in both modes.
- R10: A suspended load that hits a written line pulses fwd_hit_o for one cycle, in the cycle after the request, but only while no failure is flagged. A hit on a line that was only read gives no pulse.
- R11: Once either failure flag is set, it stays set until commit or abort. After that, no allocation or flag update occurs and the other failure flag is not raised.
- R12: A commit or abort pulse empties the table, clears all outputs and ends the transaction by the next cycle. It takes priority over any other request in the same cycle.
- R13: Local and snoop requests while no transaction is active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_begin_i | input | 1 | Begin-transaction pulse |
| tx_mode_i | input | 1 | Mode for begin: 0 atomic, 1 rollback-only |
| tx_commit_i | input | 1 | Commit pulse |
| tx_abort_i | input | 1 | Abort pulse |
| susp_i | input | 1 | Transaction suspended (level) |
| loc_vld_i | input | 1 | Local access valid |
| loc_wr_i | input | 1 | Local access is a store |
| loc_line_i | input | LINE_W | Local access line address |
| snp_vld_i | input | 1 | Snoop from another agent valid |
| snp_wr_i | input | 1 | Snoop is a write |
| snp_line_i | input | LINE_W | Snoop line address |
| tx_active_o | output | 1 | A transaction is in progress |
| fail_conflict_o | output | 1 | Sticky conflict failure |
| fail_capacity_o | output | 1 | Sticky footprint-overflow failure |
| fwd_hit_o | output | 1 | Suspended load hit a written line (one-cycle pulse) |

## Verification
The hardest case to reach is the capacity boundary combined with failure stickiness. The bench first fills all sixteen entries through the local port. It then revisits held lines to show that they use no new entries, and only then adds a seventeenth line. It also raises a conflict first and afterwards streams more new lines than the table can hold, to show that no capacity failure follows. Suspended-mode behaviour is reached by building a mixed read/written footprint before raising susp_i. Entries that were never allocated show up afterwards as the absence of a conflict on a snoop write.

// File: rtl/txfp_pkg.sv
package txfp_pkg;

    // Transaction kind latched at begin
    typedef enum logic {
        MODE_ATOMIC   = 1'b0,
        MODE_ROLLBACK = 1'b1
    } txmode_e;

    // A request on the local or snoop port
    typedef struct packed {
        logic vld;
        logic wr;
    } acc_t;

    // Update command for one table entry
    typedef struct packed {
        logic en;
        logic alloc;
        logic set_rd;
        logic set_wr;
    } upd_t;

    function automatic int idx_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/txfp_cam.sv
module txfp_cam
    import txfp_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int LINE_W  = 42,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  upd_t               upd_i,
    input  logic [IDX_W-1:0]   upd_idx_i,
    input  logic [LINE_W-1:0]  upd_line_i,
    input  logic [LINE_W-1:0]  qa_line_i,
    input  logic [LINE_W-1:0]  qb_line_i,
    output logic [NUM_ENT-1:0] qa_hit_o,
    output logic [NUM_ENT-1:0] qb_hit_o,
    output logic [NUM_ENT-1:0] vld_o,
    output logic [NUM_ENT-1:0] acc_o,
    output logic [NUM_ENT-1:0] wr_o
);

    generate
        for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
            logic              v_q;
            logic              r_q;
            logic              w_q;
            logic [LINE_W-1:0] t_q;
            logic              sel;

            assign sel = upd_i.en && (upd_idx_i == IDX_W'(g));

            always_ff @(posedge clk) begin
                if (rst || clr_i) begin
                    v_q <= 1'b0;
                    r_q <= 1'b0;
                    w_q <= 1'b0;
                end else if (sel) begin
                    if (upd_i.alloc) begin
                        v_q <= 1'b1;
                        r_q <= upd_i.set_rd;
                        w_q <= upd_i.set_wr;
                    end else begin
                        r_q <= r_q | upd_i.set_rd;
                        w_q <= w_q | upd_i.set_wr;
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (sel && upd_i.alloc) begin
                    t_q <= upd_line_i;
                end
            end

            assign qa_hit_o[g] = v_q && (t_q == qa_line_i);
            assign qb_hit_o[g] = v_q && (t_q == qb_line_i);
            assign vld_o[g]    = v_q;
            assign acc_o[g]    = v_q && (r_q || w_q);
            assign wr_o[g]     = v_q && w_q;
        end
    endgenerate

endmodule

// File: rtl/txfp_pick.sv
module txfp_pick #(
    parameter int NUM_ENT = 16,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_ENT-1:0] vld_i,
    input  logic [NUM_ENT-1:0] hit_i,
    output logic [IDX_W-1:0]   free_idx_o,
    output logic               full_o,
    output logic [IDX_W-1:0]   hit_idx_o
);

    // Lowest free slot
    always_comb begin
        logic found;
        found      = 1'b0;
        free_idx_o = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!vld_i[i] && !found) begin
                free_idx_o = IDX_W'(i);
                found      = 1'b1;
            end
        end
    end

    assign full_o = &vld_i;

    // A line is held at most once, so hits are one-hot: OR the indices
    always_comb begin
        hit_idx_o = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (hit_i[i]) begin
                hit_idx_o = hit_idx_o | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/txfp_ctrl.sv
module txfp_ctrl
    import txfp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             begin_i,
    input  txmode_e          mode_i,
    input  logic             commit_i,
    input  logic             abort_i,
    input  logic             susp_i,
    input  acc_t             loc_i,
    input  acc_t             snp_i,
    input  logic             loc_hit_i,
    input  logic             loc_hit_wr_i,
    input  logic             snp_hit_acc_i,
    input  logic             snp_hit_wr_i,
    input  logic             full_i,
    input  logic [IDX_W-1:0] free_idx_i,
    input  logic [IDX_W-1:0] hit_idx_i,
    output upd_t             upd_o,
    output logic [IDX_W-1:0] upd_idx_o,
    output logic             clr_o,
    output logic             active_o,
    output logic             fail_cf_o,
    output logic             fail_cap_o,
    output logic             fwd_o
);

    logic in_tx_q, rot_q, cf_q, cap_q, fwd_q;
    logic failed, clr, track, cap_hit, susp_cf, snp_cf, fwd_d;

    assign failed = cf_q || cap_q;
    assign clr    = commit_i || abort_i;

    // Local access that should be recorded
    assign track   = in_tx_q && !susp_i && loc_i.vld && !failed
                     && (!rot_q || loc_i.wr);
    assign cap_hit = track && !loc_hit_i && full_i;

    always_comb begin
        upd_o.en     = track && !cap_hit && !clr;
        upd_o.alloc  = !loc_hit_i;
        upd_o.set_rd = !loc_i.wr;
        upd_o.set_wr = loc_i.wr;
        upd_idx_o    = loc_hit_i ? hit_idx_i : free_idx_i;
    end

    assign susp_cf = in_tx_q && susp_i && loc_i.vld && loc_i.wr
                     && loc_hit_i && !failed;
    assign snp_cf  = in_tx_q && !rot_q && snp_i.vld && !failed
                     && (snp_i.wr ? snp_hit_acc_i : snp_hit_wr_i);
    assign fwd_d   = in_tx_q && susp_i && loc_i.vld && !loc_i.wr
                     && loc_hit_wr_i && !failed;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            in_tx_q <= 1'b0;
            rot_q   <= 1'b0;
            cf_q    <= 1'b0;
            cap_q   <= 1'b0;
            fwd_q   <= 1'b0;
        end else begin
            if (begin_i && !in_tx_q) begin
                in_tx_q <= 1'b1;
                rot_q   <= (mode_i == MODE_ROLLBACK);
            end
            cf_q  <= cf_q | susp_cf | snp_cf;
            cap_q <= cap_q | cap_hit;
            fwd_q <= fwd_d;
        end
    end

    assign clr_o      = clr;
    assign active_o   = in_tx_q;
    assign fail_cf_o  = cf_q;
    assign fail_cap_o = cap_q;
    assign fwd_o      = fwd_q;

endmodule

// File: rtl/txfp_tracker.sv
module txfp_tracker
    import txfp_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int LINE_W  = 42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_begin_i,
    input  logic              tx_mode_i,
    input  logic              tx_commit_i,
    input  logic              tx_abort_i,
    input  logic              susp_i,
    input  logic              loc_vld_i,
    input  logic              loc_wr_i,
    input  logic [LINE_W-1:0] loc_line_i,
    input  logic              snp_vld_i,
    input  logic              snp_wr_i,
    input  logic [LINE_W-1:0] snp_line_i,
    output logic              tx_active_o,
    output logic              fail_conflict_o,
    output logic              fail_capacity_o,
    output logic              fwd_hit_o
);

    localparam int IDX_W = idx_width(NUM_ENT);

    acc_t               loc, snp;
    upd_t               upd;
    logic [IDX_W-1:0]   upd_idx, free_idx, hit_idx;
    logic [NUM_ENT-1:0] qa_hit, qb_hit, vld, acc, wrf;
    logic               full, clr;

    assign loc = '{vld: loc_vld_i, wr: loc_wr_i};
    assign snp = '{vld: snp_vld_i, wr: snp_wr_i};

    txfp_cam #(
        .NUM_ENT(NUM_ENT),
        .LINE_W (LINE_W),
        .IDX_W  (IDX_W)
    ) cam_i (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (clr),
        .upd_i     (upd),
        .upd_idx_i (upd_idx),
        .upd_line_i(loc_line_i),
        .qa_line_i (loc_line_i),
        .qb_line_i (snp_line_i),
        .qa_hit_o  (qa_hit),
        .qb_hit_o  (qb_hit),
        .vld_o     (vld),
        .acc_o     (acc),
        .wr_o      (wrf)
    );

    txfp_pick #(
        .NUM_ENT(NUM_ENT),
        .IDX_W  (IDX_W)
    ) pick_i (
        .vld_i     (vld),
        .hit_i     (qa_hit),
        .free_idx_o(free_idx),
        .full_o    (full),
        .hit_idx_o (hit_idx)
    );

    txfp_ctrl #(
        .IDX_W(IDX_W)
    ) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .begin_i      (tx_begin_i),
        .mode_i       (txmode_e'(tx_mode_i)),
        .commit_i     (tx_commit_i),
        .abort_i      (tx_abort_i),
        .susp_i       (susp_i),
        .loc_i        (loc),
        .snp_i        (snp),
        .loc_hit_i    (|qa_hit),
        .loc_hit_wr_i (|(qa_hit & wrf)),
        .snp_hit_acc_i(|(qb_hit & acc)),
        .snp_hit_wr_i (|(qb_hit & wrf)),
        .full_i       (full),
        .free_idx_i   (free_idx),
        .hit_idx_i    (hit_idx),
        .upd_o        (upd),
        .upd_idx_o    (upd_idx),
        .clr_o        (clr),
        .active_o     (tx_active_o),
        .fail_cf_o    (fail_conflict_o),
        .fail_cap_o   (fail_capacity_o),
        .fwd_o        (fwd_hit_o)
    );

endmodule

// File: rtl/txfp_tracker_chk.sv
module txfp_tracker_chk (
    input logic clk,
    input logic rst,
    input logic tx_commit_i,
    input logic tx_abort_i,
    input logic susp_i,
    input logic loc_vld_i,
    input logic loc_wr_i,
    input logic tx_active_o,
    input logic fail_conflict_o,
    input logic fail_capacity_o,
    input logic fwd_hit_o
);

    // R1: outputs idle after a reset cycle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!tx_active_o && !fail_conflict_o && !fail_capacity_o && !fwd_hit_o));

    // R12: commit or abort clears everything by the next cycle
    a_r12_clear: assert property (@(posedge clk) disable iff (rst)
        (tx_commit_i || tx_abort_i) |=>
            (!tx_active_o && !fail_conflict_o && !fail_capacity_o && !fwd_hit_o));

    // R11: conflict flag is sticky until cleared
    a_r11_cf_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail_conflict_o && !tx_commit_i && !tx_abort_i) |=> fail_conflict_o);

    // R11: capacity flag is sticky until cleared
    a_r11_cap_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail_capacity_o && !tx_commit_i && !tx_abort_i) |=> fail_capacity_o);

    // R11: a later capacity failure never follows a conflict
    a_r11_first_cause: assert property (@(posedge clk) disable iff (rst)
        fail_conflict_o |=> !$rose(fail_capacity_o));

    // R13: nothing is flagged while idle
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !tx_active_o |=> (!fail_conflict_o && !fail_capacity_o && !fwd_hit_o));

    // R10: forward pulse only after a suspended load
    a_r10_fwd_cause: assert property (@(posedge clk) disable iff (rst)
        !(loc_vld_i && !loc_wr_i && susp_i) |=> !fwd_hit_o);

endmodule

bind txfp_tracker txfp_tracker_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .tx_commit_i    (tx_commit_i),
    .tx_abort_i     (tx_abort_i),
    .susp_i         (susp_i),
    .loc_vld_i      (loc_vld_i),
    .loc_wr_i       (loc_wr_i),
    .tx_active_o    (tx_active_o),
    .fail_conflict_o(fail_conflict_o),
    .fail_capacity_o(fail_capacity_o),
    .fwd_hit_o      (fwd_hit_o)
);

// File: tb/txfp_tracker_tb_top.sv
module txfp_tracker_tb_top;

    localparam int LW = 42;
    localparam int NE = 16;

    logic clk = 1'b0;
    logic rst;
    logic tx_begin_i, tx_mode_i, tx_commit_i, tx_abort_i, susp_i;
    logic loc_vld_i, loc_wr_i, snp_vld_i, snp_wr_i;
    logic [LW-1:0] loc_line_i, snp_line_i;
    logic tx_active_o, fail_conflict_o, fail_capacity_o, fwd_hit_o;

    always #2.5 clk = ~clk;

    txfp_tracker #(.NUM_ENT(NE), .LINE_W(LW)) dut_i (
        .clk(clk), .rst(rst),
        .tx_begin_i(tx_begin_i), .tx_mode_i(tx_mode_i),
        .tx_commit_i(tx_commit_i), .tx_abort_i(tx_abort_i),
        .susp_i(susp_i),
        .loc_vld_i(loc_vld_i), .loc_wr_i(loc_wr_i), .loc_line_i(loc_line_i),
        .snp_vld_i(snp_vld_i), .snp_wr_i(snp_wr_i), .snp_line_i(snp_line_i),
        .tx_active_o(tx_active_o), .fail_conflict_o(fail_conflict_o),
        .fail_capacity_o(fail_capacity_o), .fwd_hit_o(fwd_hit_o)
    );

    typedef struct {
        string req;
        bit    act;
        bit    cf;
        bit    cap;
        bit    fwd;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit e_act = 0, e_cf = 0, e_cap = 0, e_fwd = 0;
    bit s_susp = 0;
    bit done = 0;

    function automatic logic [LW-1:0] ln(input int n);
        return {1'b1, (LW-1)'(n)};
    endfunction

    task automatic cyc(input bit lv, input bit lw, input logic [LW-1:0] la,
                       input bit sv, input bit sw, input logic [LW-1:0] sa,
                       input bit bg, input bit md, input bit cm, input bit ab,
                       input string req);
        item_t it;
        @(negedge clk);
        loc_vld_i = lv; loc_wr_i = lw; loc_line_i = la;
        snp_vld_i = sv; snp_wr_i = sw; snp_line_i = sa;
        tx_begin_i = bg; tx_mode_i = md; tx_commit_i = cm; tx_abort_i = ab;
        susp_i = s_susp;
        it.req = req; it.act = e_act; it.cf = e_cf; it.cap = e_cap; it.fwd = e_fwd;
        q.push_back(it);
        e_fwd = 0;
    endtask

    task automatic nop(input string r);           cyc(0,0,'0,0,0,'0,0,0,0,0,r); endtask
    task automatic ld(input int n, input string r); cyc(1,0,ln(n),0,0,'0,0,0,0,0,r); endtask
    task automatic st(input int n, input string r); cyc(1,1,ln(n),0,0,'0,0,0,0,0,r); endtask
    task automatic snr(input logic [LW-1:0] a, input string r); cyc(0,0,'0,1,0,a,0,0,0,0,r); endtask
    task automatic snw(input logic [LW-1:0] a, input string r); cyc(0,0,'0,1,1,a,0,0,0,0,r); endtask
    task automatic tbeg(input bit md, input string r); cyc(0,0,'0,0,0,'0,1,md,0,0,r); endtask
    task automatic tcommit(input string r); e_act=0; e_cf=0; e_cap=0; cyc(0,0,'0,0,0,'0,0,0,1,0,r); endtask
    task automatic tabort(input string r);  e_act=0; e_cf=0; e_cap=0; cyc(0,0,'0,0,0,'0,0,0,0,1,r); endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: compare one expected item per driven cycle
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (tx_active_o !== it.act || fail_conflict_o !== it.cf ||
                fail_capacity_o !== it.cap || fwd_hit_o !== it.fwd) begin
                n_fail++;
                $display("FAIL %s: act/cf/cap/fwd actual=%b%b%b%b expected=%b%b%b%b",
                         it.req, tx_active_o, fail_conflict_o, fail_capacity_o, fwd_hit_o,
                         it.act, it.cf, it.cap, it.fwd);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1;
        tx_begin_i = 0; tx_mode_i = 0; tx_commit_i = 0; tx_abort_i = 0; susp_i = 0;
        loc_vld_i = 0; loc_wr_i = 0; loc_line_i = '0;
        snp_vld_i = 0; snp_wr_i = 0; snp_line_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        nop("R1 reset state");
        nop("R1 reset state");

        // R13: idle accesses ignored
        st(1, "R13 store while idle");
        snw(ln(1), "R13 snoop while idle");
        e_act = 1; tbeg(0, "R2 begin atomic");
        snw(ln(1), "R13 idle store not tracked");

        // R3 / R12
        ld(2, "R3 load tracked");
        e_cf = 1; snw(ln(2), "R3 snoop write hits read line");
        tcommit("R12 commit clears");
        snw(ln(2), "R12 no conflict after commit");

        // R4 / R5
        e_act = 1; tbeg(0, "R2 begin atomic");
        ld(3, "R4 load");
        snr(ln(3), "R4 snoop read of read-only line");
        st(4, "R4 store");
        snw({1'b0, (LW-1)'(4)}, "R5 msb differs");
        snr({1'b1, (LW-1)'(5)}, "R5 other line");
        e_cf = 1; snr(ln(4), "R4 snoop read hits written line");
        tabort("R12 abort clears");

        // R2 / R7: rollback-only, second begin ignored
        e_act = 1; tbeg(1, "R2 begin rollback-only");
        tbeg(0, "R2 nested begin ignored");
        ld(5, "R7 load");
        snw(ln(5), "R7 load untracked, no snoop check");
        st(5, "R7 store");
        snw(ln(5), "R2 mode kept rollback-only, R7 no conflict");
        tcommit("R12 commit");

        // R6 capacity
        e_act = 1; tbeg(0, "R2 begin atomic");
        for (int i = 0; i < NE; i++) ld(100 + i, "R6 fill");
        ld(100, "R6 revisit no alloc");
        st(101, "R6 upgrade no alloc");
        e_cap = 1; ld(200, "R6 overflow");
        snw(ln(102), "R11 no conflict after capacity");
        tabort("R12 abort");

        // R7 capacity counts stores only
        e_act = 1; tbeg(1, "R2 begin rollback-only");
        for (int i = 0; i < NE; i++) ld(300 + i, "R7 loads not recorded");
        for (int i = 0; i < NE; i++) st(400 + i, "R7 stores recorded");
        st(400, "R7 store revisit");
        e_cap = 1; st(500, "R7 store overflow");
        tcommit("R12 commit");

        // R8 / R9 / R10
        e_act = 1; tbeg(0, "R2 begin atomic");
        st(20, "R10 setup store");
        ld(21, "R10 setup load");
        s_susp = 1;
        e_fwd = 1; ld(20, "R10 suspended load hits written");
        ld(21, "R10 read-only line no forward");
        ld(22, "R8 suspended load untracked");
        st(23, "R8 suspended store untracked");
        s_susp = 0;
        snw(ln(22), "R8 no allocation from suspended load");
        snw(ln(23), "R8 no allocation from suspended store");
        s_susp = 1;
        e_cf = 1; st(21, "R9 suspended store to tracked line");
        ld(20, "R10 no forward after failure");
        s_susp = 0;
        tabort("R12 abort");

        // R11: allocation ignored after conflict
        e_act = 1; tbeg(0, "R2 begin atomic");
        ld(30, "R11 setup");
        e_cf = 1; snw(ln(30), "R3 conflict");
        for (int i = 0; i <= NE; i++) ld(600 + i, "R11 no capacity after conflict");
        tabort("R12 abort");

        // R9 in rollback-only mode
        e_act = 1; tbeg(1, "R2 begin rollback-only");
        st(50, "R9 setup store");
        s_susp = 1;
        e_cf = 1; st(50, "R9 suspended store rollback-only");
        s_susp = 0;
        tcommit("R12 commit");

        // R12: immediate restart sees empty table
        e_act = 1; tbeg(0, "R2 begin atomic");
        st(60, "R12 setup");
        tabort("R12 abort");
        e_act = 1; tbeg(0, "R12 begin right after abort");
        snr(ln(60), "R12 table emptied");
        tcommit("R12 commit");
        nop("R13 idle");

        repeat (3) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule